// File: doc/BRIEF.md
# Channelised Timer Control Register Bank

This block is the register front end for an array of timer channels. Every channel owns a 64-byte window in the address space. The upper address bits pick the channel and the low six bits pick a word inside the window. A window holds five things:

- a live count word, which reads the channel counter and loads it when written;
- a reload word;
- two match words;
- a pair of control registers, one that sets bits and one that clears them.

The block keeps each channel's four control bits and its interrupt status flag. It drives the control bits straight to the counters. The counters themselves live outside the block.

The control bits are changed only through the set and clear registers. A write to either register touches only the bits written as one, so software never has to read, modify and write the control word back. The two registers also order their effects when the run bit moves together with other bits:

- A set that starts a channel applies the configuration bits first and raises the run bit one cycle later.
- A clear that stops a channel drops the run bit first and removes the configuration bits one cycle later.

The interrupt status flag is set by a one-cycle event pulse from the channel. It is cleared through the clear register and reads back next to the control bits.

Top module: `tmr_ctl_regs`

## Requirements
- R1: After reset, every control bit, every status flag, every reload and match word, every load strobe and the response port are zero.
- R2: The channel index is taken from bus_addr[AW-1:6] and the word from bus_addr[5:0]. Reload sits at 0x04, first match at 0x08 and second match at 0x0C. Each is written whole and reads back what was written. Offsets 0x14, 0x18 and above read as zero.
- R3: Reading offset 0x00 returns the channel's live count input. Writing it raises that channel's cnt_load for exactly one cycle, with the written value on cnt_load_val.
- R4: Reading offset 0x10 returns the control bits in [3:0] and the status flag in bit 16, with all other bits zero. The control bits are: bit 0 run, bit 1 external clock select, bit 2 interrupt enable, bit 3 pulse enable.
- R5: A write to 0x10 sets every control bit written as one and leaves bits written as zero unchanged. Bit 16 of this register has no effect on the status flag.
- R6: Suppose a 0x10 write newly sets run together with at least one newly set configuration bit. Then the configuration bits appear on the outputs in the cycle after the write, and run appears one cycle later. A write that newly sets run alone raises it in the cycle after the write.
- R7: A write to 0x14 clears every control bit written as one. If it clears run together with at least one other set bit, run drops in the cycle after the write and the other bits drop one cycle later.
- R8: An evt_in pulse sets the channel's status flag. Bit 16 of a 0x14 write clears it. When both occur in the same cycle, the flag stays set.
- R9: An access whose channel index is NCH or more changes no state and reads as zero.
- R10: A read request is answered one cycle later with rsp_valid high. In every other cycle rsp_valid is low and rsp_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DW | Read data |
| evt_in | input | NCH | One-cycle event pulse per channel |
| cnt_cur | input | NCH*DW | Live count of each channel |
| cnt_load | output | NCH | One-cycle count load strobe |
| cnt_load_val | output | DW | Value to load |
| reload_out | output | NCH*DW | Reload words |
| match_a_out | output | NCH*DW | First match words |
| match_b_out | output | NCH*DW | Second match words |
| run_en | output | NCH | Run bit per channel |
| ext_clk_sel | output | NCH | External clock select per channel |
| irq_en | output | NCH | Interrupt enable per channel |
| pulse_en | output | NCH | Pulse enable per channel |
| irq_status | output | NCH | Interrupt status flag per channel |

## Verification
The bench goes after the cycle ordering of mixed set and clear writes.

- If a design raised run in the same cycle as the configuration bits, a channel would start counting on its old clock selection.
- If a design dropped configuration bits before run, a running channel would briefly change its clock source.

The event and clear collision is driven directly. A design that lets the clear win would lose an interrupt.

Indexes just past the last channel are written and read. A decoder that truncates the index would alias them onto channel 0 and corrupt its reload word. Random set and clear masks that include bit 16 catch a set register that touches the status flag.

// File: rtl/tmr_ctl_pkg.sv
package tmr_ctl_pkg;

   localparam int unsigned WIN_BITS = 6;

   localparam logic [5:0] OFS_COUNT    = 6'h00;
   localparam logic [5:0] OFS_RELOAD   = 6'h04;
   localparam logic [5:0] OFS_MATCH_A  = 6'h08;
   localparam logic [5:0] OFS_MATCH_B  = 6'h0C;
   localparam logic [5:0] OFS_CTRL_SET = 6'h10;
   localparam logic [5:0] OFS_CTRL_CLR = 6'h14;

   // control nibble layout, decoded by the channel counters
   localparam int unsigned CB_RUN    = 0;
   localparam int unsigned CB_EXTCLK = 1;
   localparam int unsigned CB_IRQEN  = 2;
   localparam int unsigned CB_PULSE  = 3;
   localparam int unsigned CTRL_W    = 4;
   localparam int unsigned STAT_BIT  = 16;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_COUNT,
      SEL_RELOAD,
      SEL_MATCH_A,
      SEL_MATCH_B,
      SEL_CTRL_SET,
      SEL_CTRL_CLR
   } reg_sel_e;

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
   import tmr_ctl_pkg::*;
#(
   parameter int unsigned AW  = 12,
   parameter int unsigned NCH = 8
) (
   input  logic [AW-1:0]  addr,
   output logic           in_range,
   output reg_sel_e       sel,
   output logic [NCH-1:0] ch_hit
);
   localparam int unsigned IDXW = AW - WIN_BITS;

   logic [IDXW-1:0] idx;
   logic [5:0]      ofs;

   assign idx = addr[AW-1:WIN_BITS];
   assign ofs = addr[WIN_BITS-1:0];

   // one extra bit so NCH == 2**IDXW does not wrap
   assign in_range = ({1'b0, idx} < (IDXW+1)'(NCH));

   for (genvar i = 0; i < NCH; i++) begin : g_hit
      assign ch_hit[i] = in_range && (idx == IDXW'(i));
   end

   always_comb begin
      sel = SEL_NONE;
      if (in_range) begin
         unique case (ofs)
            OFS_COUNT:    sel = SEL_COUNT;
            OFS_RELOAD:   sel = SEL_RELOAD;
            OFS_MATCH_A:  sel = SEL_MATCH_A;
            OFS_MATCH_B:  sel = SEL_MATCH_B;
            OFS_CTRL_SET: sel = SEL_CTRL_SET;
            OFS_CTRL_CLR: sel = SEL_CTRL_CLR;
            default:      sel = SEL_NONE;
         endcase
      end
   end
endmodule

// File: rtl/tmr_chan_ctl.sv
module tmr_chan_ctl
   import tmr_ctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_we,
   input  logic              clr_we,
   input  logic [CTRL_W-1:0] wbits,
   input  logic              stat_clr,
   input  logic              evt,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              stat_q
);
   // deferred halves of an ordered set or clear
   logic                pend_run;
   logic [CTRL_W-1:1]   pend_cfg;

   logic [CTRL_W-1:0]   base, nxt, newly, gone;
   logic                np_run;
   logic [CTRL_W-1:1]   np_cfg;

   always_comb begin
      base           = ctrl_q;
      base[CB_RUN]   = ctrl_q[CB_RUN] | pend_run;
      base[CTRL_W-1:1] = ctrl_q[CTRL_W-1:1] & ~pend_cfg;
      nxt    = base;
      np_run = 1'b0;
      np_cfg = '0;
      newly  = wbits & ~base;
      gone   = wbits & base;
      if (set_we) begin
         if (newly[CB_RUN] && (newly[CTRL_W-1:1] != '0)) begin
            nxt[CTRL_W-1:1] = base[CTRL_W-1:1] | wbits[CTRL_W-1:1];
            np_run          = 1'b1;
         end else begin
            nxt = base | wbits;
         end
      end else if (clr_we) begin
         if (gone[CB_RUN] && (gone[CTRL_W-1:1] != '0)) begin
            nxt[CB_RUN] = 1'b0;
            np_cfg      = wbits[CTRL_W-1:1];
         end else begin
            nxt = base & ~wbits;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         pend_run <= 1'b0;
         pend_cfg <= '0;
         stat_q   <= 1'b0;
      end else begin
         ctrl_q   <= nxt;
         pend_run <= np_run;
         pend_cfg <= np_cfg;
         stat_q   <= evt | (stat_q & ~stat_clr);
      end
   end
endmodule

// File: rtl/tmr_chan_words.sv
module tmr_chan_words #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_count,
   input  logic          we_reload,
   input  logic          we_match_a,
   input  logic          we_match_b,
   input  logic [DW-1:0] wdata,
   output logic          load_q,
   output logic [DW-1:0] reload_q,
   output logic [DW-1:0] match_a_q,
   output logic [DW-1:0] match_b_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_q    <= 1'b0;
         reload_q  <= '0;
         match_a_q <= '0;
         match_b_q <= '0;
      end else begin
         load_q <= we_count;
         if (we_reload)  reload_q  <= wdata;
         if (we_match_a) match_a_q <= wdata;
         if (we_match_b) match_b_q <= wdata;
      end
   end
endmodule

// File: rtl/tmr_ctl_regs.sv
module tmr_ctl_regs
   import tmr_ctl_pkg::*;
#(
   parameter int unsigned NCH = 8,
   parameter int unsigned DW  = 32,
   parameter int unsigned AW  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic              rsp_valid,
   output logic [DW-1:0]     rsp_rdata,
   input  logic [NCH-1:0]    evt_in,
   input  logic [NCH*DW-1:0] cnt_cur,
   output logic [NCH-1:0]    cnt_load,
   output logic [DW-1:0]     cnt_load_val,
   output logic [NCH*DW-1:0] reload_out,
   output logic [NCH*DW-1:0] match_a_out,
   output logic [NCH*DW-1:0] match_b_out,
   output logic [NCH-1:0]    run_en,
   output logic [NCH-1:0]    ext_clk_sel,
   output logic [NCH-1:0]    irq_en,
   output logic [NCH-1:0]    pulse_en,
   output logic [NCH-1:0]    irq_status
);
   if (DW <= STAT_BIT) begin : g_bad_dw
      $error("tmr_ctl_regs: DW must exceed the status bit position");
   end
   if (AW <= WIN_BITS) begin : g_bad_aw
      $error("tmr_ctl_regs: AW must leave room for a channel index");
   end
   if (NCH < 1 || NCH > (1 << (AW - WIN_BITS))) begin : g_bad_nch
      $error("tmr_ctl_regs: NCH does not fit the index field");
   end

   logic           in_range;
   reg_sel_e       sel;
   logic [NCH-1:0] ch_hit;
   logic           wr_go, rd_go;

   assign wr_go = bus_en &  bus_we;
   assign rd_go = bus_en & ~bus_we;

   tmr_addr_dec #(.AW(AW), .NCH(NCH)) u_dec (
      .addr     (bus_addr),
      .in_range (in_range),
      .sel      (sel),
      .ch_hit   (ch_hit)
   );

   logic [NCH-1:0][CTRL_W-1:0] ctrl_v;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic hit_w;
      assign hit_w = wr_go & ch_hit[i];

      tmr_chan_ctl u_ctl (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_we   (hit_w && sel == SEL_CTRL_SET),
         .clr_we   (hit_w && sel == SEL_CTRL_CLR),
         .wbits    (bus_wdata[CTRL_W-1:0]),
         .stat_clr (hit_w && sel == SEL_CTRL_CLR && bus_wdata[STAT_BIT]),
         .evt      (evt_in[i]),
         .ctrl_q   (ctrl_v[i]),
         .stat_q   (irq_status[i])
      );

      tmr_chan_words #(.DW(DW)) u_words (
         .clk        (clk),
         .rst_n      (rst_n),
         .we_count   (hit_w && sel == SEL_COUNT),
         .we_reload  (hit_w && sel == SEL_RELOAD),
         .we_match_a (hit_w && sel == SEL_MATCH_A),
         .we_match_b (hit_w && sel == SEL_MATCH_B),
         .wdata      (bus_wdata),
         .load_q     (cnt_load[i]),
         .reload_q   (reload_out[i*DW +: DW]),
         .match_a_q  (match_a_out[i*DW +: DW]),
         .match_b_q  (match_b_out[i*DW +: DW])
      );

      assign run_en[i]      = ctrl_v[i][CB_RUN];
      assign ext_clk_sel[i] = ctrl_v[i][CB_EXTCLK];
      assign irq_en[i]      = ctrl_v[i][CB_IRQEN];
      assign pulse_en[i]    = ctrl_v[i][CB_PULSE];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_load_val <= '0;
      end else if (wr_go && sel == SEL_COUNT) begin
         cnt_load_val <= bus_wdata;
      end
   end

   // one-hot read mux over channels
   logic [DW-1:0] rd_val;
   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NCH; i++) begin
         if (ch_hit[i]) begin
            unique case (sel)
               SEL_COUNT:    rd_val = rd_val | cnt_cur[i*DW +: DW];
               SEL_RELOAD:   rd_val = rd_val | reload_out[i*DW +: DW];
               SEL_MATCH_A:  rd_val = rd_val | match_a_out[i*DW +: DW];
               SEL_MATCH_B:  rd_val = rd_val | match_b_out[i*DW +: DW];
               SEL_CTRL_SET: begin
                  rd_val[CTRL_W-1:0] = rd_val[CTRL_W-1:0] | ctrl_v[i];
                  rd_val[STAT_BIT]   = rd_val[STAT_BIT] | irq_status[i];
               end
               default:      rd_val = rd_val;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_go;
         rsp_rdata <= rd_go ? rd_val : '0;
      end
   end
endmodule

// File: rtl/tmr_ctl_regs_chk.sv
module tmr_ctl_regs_chk #(
   parameter int unsigned NCH = 8,
   parameter int unsigned AW  = 12
) (
   input logic           clk,
   input logic           rst_n,
   input logic           bus_en,
   input logic           bus_we,
   input logic [AW-1:0]  bus_addr,
   input logic           wbit_run,
   input logic           rsp_valid,
   input logic [NCH-1:0] evt_in,
   input logic [NCH-1:0] irq_status,
   input logic [NCH-1:0] cnt_load,
   input logic [NCH-1:0] run_en
);
   localparam int unsigned IDXW = AW - 6;

   logic [IDXW-1:0] idx;
   logic            in_rng;
   logic [NCH-1:0]  ch_mask;

   assign idx     = bus_addr[AW-1:6];
   assign in_rng  = ({1'b0, idx} < (IDXW+1)'(NCH));
   assign ch_mask = in_rng ? (NCH'(1) << idx) : '0;

   // R8: an event always leaves the flag set, even against a clear
   a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_in != '0) |=> ((irq_status & $past(evt_in)) == $past(evt_in)));

   // R8 / R5: the flag only rises after an event
   a_r8_status_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_status & ~$past(irq_status) & ~$past(evt_in)) == '0));

   // R9: out-of-range writes never strobe a load
   a_r9_reject_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && !in_rng) |=> (cnt_load == '0));

   // R7: clearing run takes effect in the very next cycle
   a_r7_disable_first: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && in_rng && bus_addr[5:0] == 6'h14 && wbit_run)
      |=> ((run_en & $past(ch_mask)) == '0));

   // R10: response follows a read by exactly one cycle
   a_r10_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we) |=> rsp_valid);
   a_r10_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_en && !bus_we) |=> !rsp_valid);
endmodule

bind tmr_ctl_regs tmr_ctl_regs_chk #(.NCH(NCH), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_en     (bus_en),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .wbit_run   (bus_wdata[0]),
   .rsp_valid  (rsp_valid),
   .evt_in     (evt_in),
   .irq_status (irq_status),
   .cnt_load   (cnt_load),
   .run_en     (run_en)
);

// File: tb/tmr_ctl_regs_tb.sv
`timescale 1ns/1ps
module tmr_ctl_regs_tb_top;
   localparam int NCH = 8;
   localparam int DW  = 32;
   localparam int AW  = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_en = 1'b0, bus_we = 1'b0;
   logic [AW-1:0]     bus_addr = '0;
   logic [DW-1:0]     bus_wdata = '0;
   logic              rsp_valid;
   logic [DW-1:0]     rsp_rdata;
   logic [NCH-1:0]    evt_in = '0;
   logic [NCH*DW-1:0] cnt_cur;
   logic [NCH-1:0]    cnt_load;
   logic [DW-1:0]     cnt_load_val;
   logic [NCH*DW-1:0] reload_out, match_a_out, match_b_out;
   logic [NCH-1:0]    run_en, ext_clk_sel, irq_en, pulse_en, irq_status;

   always #2.5 clk = ~clk;

   for (genvar i = 0; i < NCH; i++) begin : g_cnt
      assign cnt_cur[i*DW +: DW] = 32'hC000_0000 + 32'(i * 17);
   end

   tmr_ctl_regs #(.NCH(NCH), .DW(DW), .AW(AW)) dut_i (.*);

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [3:0]  m_ctrl [NCH];
   logic        m_stat [NCH];
   logic [31:0] m_rel [NCH], m_ma [NCH], m_mb [NCH];

   function automatic logic [AW-1:0] adr(int ch, logic [5:0] ofs);
      return AW'((ch << 6) | int'(ofs));
   endfunction

   function automatic logic [31:0] exp_ctrl_word(int ch);
      if (ch >= NCH) return 32'h0;
      return {15'h0, m_stat[ch], 12'h0, m_ctrl[ch]};
   endfunction

   function automatic logic [31:0] exp_word(int ch, logic [5:0] ofs);
      if (ch >= NCH) return 32'h0;
      case (ofs)
         6'h00: return 32'hC000_0000 + 32'(ch * 17);
         6'h04: return m_rel[ch];
         6'h08: return m_ma[ch];
         6'h0C: return m_mb[ch];
         6'h10: return exp_ctrl_word(ch);
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_en = 1'b0;
      d = rsp_rdata;
      check("R10", 32'(rsp_valid), 32'h1, "rsp_valid after read");
   endtask

   task automatic cmp_outputs(string req);
      logic [NCH-1:0] er, ee, ei, ep, es;
      for (int i = 0; i < NCH; i++) begin
         er[i] = m_ctrl[i][0]; ee[i] = m_ctrl[i][1];
         ei[i] = m_ctrl[i][2]; ep[i] = m_ctrl[i][3]; es[i] = m_stat[i];
      end
      check(req, 32'(run_en), 32'(er), "run_en");
      check(req, 32'(ext_clk_sel), 32'(ee), "ext_clk_sel");
      check(req, 32'(irq_en), 32'(ei), "irq_en");
      check(req, 32'(pulse_en), 32'(ep), "pulse_en");
      check(req, 32'(irq_status), 32'(es), "irq_status");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NCH; i++) begin
         m_ctrl[i] = '0; m_stat[i] = 1'b0;
         m_rel[i] = '0; m_ma[i] = '0; m_mb[i] = '0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      cmp_outputs("R1");
      check("R1", reload_out[31:0] | match_a_out[31:0] | match_b_out[31:0], 32'h0, "words");
      check("R1", 32'(cnt_load), 32'h0, "cnt_load");
      check("R1", rsp_rdata, 32'h0, "rsp_rdata");

      // R2: word write/readback, unused offsets
      wr(adr(3, 6'h04), 32'hDEAD_0004); m_rel[3] = 32'hDEAD_0004;
      wr(adr(3, 6'h08), 32'h0000_0A08); m_ma[3]  = 32'h0000_0A08;
      wr(adr(3, 6'h0C), 32'h0000_0B0C); m_mb[3]  = 32'h0000_0B0C;
      rd(adr(3, 6'h04), d); check("R2", d, 32'hDEAD_0004, "reload readback");
      rd(adr(3, 6'h08), d); check("R2", d, 32'h0000_0A08, "match a readback");
      rd(adr(3, 6'h0C), d); check("R2", d, 32'h0000_0B0C, "match b readback");
      check("R2", reload_out[3*DW +: DW], 32'hDEAD_0004, "reload_out");
      rd(adr(3, 6'h18), d); check("R2", d, 32'h0, "offset 0x18");
      rd(adr(3, 6'h14), d); check("R2", d, 32'h0, "offset 0x14");
      @(negedge clk);
      check("R10", 32'(rsp_valid), 32'h0, "rsp_valid idle");
      check("R10", rsp_rdata, 32'h0, "rsp_rdata idle");

      // R3: count read and load strobe
      rd(adr(4, 6'h00), d); check("R3", d, 32'hC000_0044, "count read");
      wr(adr(5, 6'h00), 32'h0000_1234);
      check("R3", 32'(cnt_load), 32'h20, "cnt_load pulse");
      check("R3", cnt_load_val, 32'h0000_1234, "cnt_load_val");
      @(negedge clk);
      check("R3", 32'(cnt_load), 32'h0, "cnt_load single cycle");

      // R6: ordered start
      wr(adr(2, 6'h10), 32'h0000_0007);
      check("R6", 32'(run_en[2]), 32'h0, "run held back");
      check("R6", 32'({irq_en[2], ext_clk_sel[2]}), 32'h3, "config first");
      @(negedge clk);
      check("R6", 32'(run_en[2]), 32'h1, "run one cycle later");
      m_ctrl[2] = 4'h7;
      wr(adr(6, 6'h10), 32'h0000_0001);
      check("R6", 32'(run_en[6]), 32'h1, "run alone immediate");
      m_ctrl[6] = 4'h1;

      // R4 / R5: readback layout, bit 16 of set register inert
      wr(adr(2, 6'h10), 32'h0001_0008); m_ctrl[2] = 4'hF;
      rd(adr(2, 6'h10), d); check("R4", d, 32'h0000_000F, "ctrl readback");
      check("R5", 32'(irq_status[2]), 32'h0, "set bit16 ignored");

      // R7: ordered stop
      wr(adr(2, 6'h14), 32'h0000_0005);
      check("R7", 32'(run_en[2]), 32'h0, "run drops first");
      check("R7", 32'(irq_en[2]), 32'h1, "irq_en held");
      @(negedge clk);
      check("R7", 32'(irq_en[2]), 32'h0, "irq_en later");
      check("R7", 32'({pulse_en[2], ext_clk_sel[2]}), 32'h3, "untouched bits kept");
      m_ctrl[2] = 4'hA;

      // R8: event sets, collision with clear keeps it set
      @(negedge clk); evt_in[1] = 1'b1;
      @(negedge clk); evt_in[1] = 1'b0;
      check("R8", 32'(irq_status[1]), 32'h1, "event sets flag");
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = adr(1, 6'h14); bus_wdata = 32'h0001_0000;
      evt_in[1] = 1'b1;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; evt_in[1] = 1'b0;
      check("R8", 32'(irq_status[1]), 32'h1, "set wins over clear");
      rd(adr(1, 6'h10), d); check("R4", d, 32'h0001_0000, "status bit 16");
      wr(adr(1, 6'h14), 32'h0001_0000);
      check("R8", 32'(irq_status[1]), 32'h0, "clear alone");

      // R9: out-of-range channel
      wr(adr(8, 6'h04), 32'h5555_AAAA);
      wr(adr(8, 6'h10), 32'h0000_000F);
      wr(adr(NCH + 8, 6'h10), 32'h0000_000F);
      @(negedge clk);
      cmp_outputs("R9");
      check("R9", reload_out[31:0], 32'h0, "no alias onto channel 0");
      rd(adr(8, 6'h04), d); check("R9", d, 32'h0, "reject read");
      rd(adr(9, 6'h10), d); check("R9", d, 32'h0, "reject ctrl read");

      // random phase: R2 R4 R5 R7 R8 R9
      for (int it = 0; it < 400; it++) begin
         int ch  = $urandom_range(0, NCH + 1);
         int op  = $urandom_range(0, 6);
         logic [31:0] v = $urandom();
         case (op)
            0: begin wr(adr(ch, 6'h10), v); if (ch < NCH) m_ctrl[ch] = m_ctrl[ch] | v[3:0]; end
            1: begin
                  wr(adr(ch, 6'h14), v);
                  if (ch < NCH) begin
                     m_ctrl[ch] = m_ctrl[ch] & ~v[3:0];
                     if (v[16]) m_stat[ch] = 1'b0;
                  end
               end
            2: begin wr(adr(ch, 6'h04), v); if (ch < NCH) m_rel[ch] = v; end
            3: begin wr(adr(ch, 6'h08), v); if (ch < NCH) m_ma[ch] = v; end
            4: begin wr(adr(ch, 6'h0C), v); if (ch < NCH) m_mb[ch] = v; end
            5: begin
                  @(negedge clk); evt_in = v[NCH-1:0];
                  @(negedge clk); evt_in = '0;
                  for (int i = 0; i < NCH; i++) if (v[i]) m_stat[i] = 1'b1;
               end
            default: ;
         endcase
         @(negedge clk);
         if (it % 4 == 0) cmp_outputs("R5 R7 R8");
         begin
            int rc = $urandom_range(0, NCH + 1);
            logic [5:0] ro = 6'($urandom_range(0, 6) * 4);
            rd(adr(rc, ro), d);
            check("R2 R4 R9", d, exp_word(rc, ro), "random readback");
         end
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule